// File: doc/BRIEF.md
# Chromosome-Configured Gate Network

This block evaluates a small feed-forward network of four programmable two-input logic gates. A 36-bit configuration word, the chromosome, selects for every gate which two signals drive it and which Boolean function it applies. The primary Boolean inputs are a, b and c. The network output is the output of the last gate. An outer search engine uses the block to score candidate chromosomes: it loads a candidate, sweeps the primary inputs and compares the output bit against a truth table. Generating, storing and evolving chromosomes is left to that engine.

The chromosome sits in a register that takes a new value on any clock edge where the load strobe is high. The output is registered, and every edge updates it from the chromosome in force at that edge and the primary inputs sampled at that edge. A selector that names the gate's own output, or the output of a later gate, reads as constant 0. This means no bit pattern can close a combinational loop. Gates that do not feed the output have no effect on it.

Top module: `chromo_gate_net`

## Requirements
- R1: While `rst_n` is low, `y` is 0 and the stored chromosome is all zeros. Reset asserts at once and releases through a two-flop synchronizer. After release, with no load, `y` equals input a, because the all-zero chromosome makes every gate compute a AND a.
- R2: On an edge where `load` is 1, `chrom_in` becomes the stored chromosome. The value of `y` after that same edge already comes from the new chromosome.
- R3: On an edge where `load` is 0, the stored chromosome keeps its value and `chrom_in` has no effect on `y`.
- R4: Gate layout: gate I uses bits [35:27], gate II [26:18], gate III [17:9] and gate IV [8:0]. Within each 9-bit field, bits [8:6] are the first selector, [5:3] the second selector and [2:0] the gate type.
- R5: Gate type codes: 000 AND, 001 NAND, 010 OR, 011 NOR, 100 NOT of the first input, 101 NOT of the second input, 110 XOR, 111 XNOR.
- R6: Selector codes: 000 and 110 both pick a, 001 and 111 both pick b, 010 picks c, 011 picks the output of gate I, 100 the output of gate II, and 101 the output of gate III. `x_in[0]` is a, `x_in[1]` is b and `x_in[2]` is c.
- R7: A selector that names the gate's own output or a later gate's output reads as constant 0.
- R8: Changing the bits of a gate that does not feed gate IV, directly or through other gates, leaves `y` unchanged.
- R9: After each edge, `y` equals the output of gate IV. Gate IV is evaluated from the chromosome in force at that edge and from `x_in` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Chromosome load strobe |
| chrom_in | input | 36 | Candidate chromosome |
| x_in | input | 3 | Primary inputs: bit 0 = a, bit 1 = b, bit 2 = c |
| y | output | 1 | Registered network output |

## Verification
On every cycle, the assertions check that the chromosome register captures on a load and holds otherwise. They also check three decoded patterns that fix the result: an inverter on the second input, an XOR of two aliased codes for a, and a gate I whose selectors all point forward, which must read as zeros. The bench scenarios are what show full truth tables. These cover the sum and carry networks of a full adder, every gate type, junk bits on gates that do not feed the output, and the value `y` takes after a reset in mid-run. Insensitivity to off-path gates can only be shown by comparing runs, so the bench covers it.

// File: rtl/cgn_pkg.sv
package cgn_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'b000,
    OP_NAND = 3'b001,
    OP_OR   = 3'b010,
    OP_NOR  = 3'b011,
    OP_INVA = 3'b100,
    OP_INVB = 3'b101,
    OP_XOR  = 3'b110,
    OP_XNOR = 3'b111
  } gate_op_e;

  // Fold the two alias codes onto the primaries they stand for.
  function automatic logic [SEL_W-1:0] sel_to_idx(input logic [SEL_W-1:0] code);
    case (code)
      3'b110:  sel_to_idx = 3'b000;
      3'b111:  sel_to_idx = 3'b001;
      default: sel_to_idx = code;
    endcase
  endfunction
endpackage

// File: rtl/cgn_gate.sv
module cgn_gate
  import cgn_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [SEL_W-1:0]   sel_a,
  input  logic [SEL_W-1:0]   sel_b,
  input  logic [OP_W-1:0]    op,
  output logic               y
);
  logic [SEL_W-1:0] idx_a;
  logic [SEL_W-1:0] idx_b;
  logic             opd_a;
  logic             opd_b;

  // Operand muxes: only earlier signals exist here, so a forward
  // or self reference finds no match and stays 0.
  always_comb begin
    idx_a = sel_to_idx(sel_a);
    idx_b = sel_to_idx(sel_b);
    opd_a = 1'b0;
    opd_b = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (idx_a == SEL_W'(k)) opd_a = src[k];
      if (idx_b == SEL_W'(k)) opd_b = src[k];
    end
  end

  always_comb begin
    case (gate_op_e'(op))
      OP_AND:  y = opd_a & opd_b;
      OP_NAND: y = ~(opd_a & opd_b);
      OP_OR:   y = opd_a | opd_b;
      OP_NOR:  y = ~(opd_a | opd_b);
      OP_INVA: y = ~opd_a;
      OP_INVB: y = ~opd_b;
      OP_XOR:  y = opd_a ^ opd_b;
      default: y = ~(opd_a ^ opd_b);
    endcase
  end
endmodule

// File: rtl/cgn_net.sv
module cgn_net
  import cgn_pkg::*;
#(
  parameter  int NUM_PRIM  = 3,
  parameter  int NUM_GATES = 4,
  localparam int FW        = 2*SEL_W + OP_W,
  localparam int CW        = NUM_GATES*FW
) (
  input  logic [NUM_PRIM-1:0] x,
  input  logic [CW-1:0]       chrom,
  output logic                y
);
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam int NSRC = NUM_PRIM + g;
    logic [FW-1:0]   field;
    logic [NSRC-1:0] src;
    logic            out;
    logic [NSRC:0]   acc;

    assign field = chrom[CW-1-g*FW -: FW];

    if (g == 0) begin : g_head
      assign src = x;
    end else begin : g_tail
      assign src = g_gate[g-1].acc;
    end

    assign acc = {out, src};

    cgn_gate #(.NUM_SRC(NSRC)) u_gate (
      .src   (src),
      .sel_a (field[FW-1 -: SEL_W]),
      .sel_b (field[OP_W+SEL_W-1 -: SEL_W]),
      .op    (field[OP_W-1:0]),
      .y     (out)
    );
  end

  assign y = g_gate[NUM_GATES-1].out;
endmodule

// File: rtl/chromo_gate_net.sv
module chromo_gate_net
  import cgn_pkg::*;
#(
  parameter  int NUM_PRIM  = 3,
  parameter  int NUM_GATES = 4,
  localparam int FW        = 2*SEL_W + OP_W,
  localparam int CW        = NUM_GATES*FW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CW-1:0]       chrom_in,
  input  logic [NUM_PRIM-1:0] x_in,
  output logic                y
);
  localparam int G1_TOP = CW - 1;
  localparam int G1_OP  = CW - FW;

  logic [1:0]    rst_sync;
  logic          rst_q;
  logic [CW-1:0] chrom_q;
  logic [CW-1:0] chrom_nxt;
  logic          net_y;
  logic          y_q;

  // Reset: asserts at once, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  always_comb begin
    chrom_nxt = chrom_q;
    if (load) chrom_nxt = chrom_in;
  end

  cgn_net #(.NUM_PRIM(NUM_PRIM), .NUM_GATES(NUM_GATES)) u_net (
    .x     (x_in),
    .chrom (chrom_nxt),
    .y     (net_y)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      chrom_q <= '0;
      y_q     <= 1'b0;
    end else begin
      if (load) chrom_q <= chrom_in;
      y_q <= net_y;
    end
  end

  assign y = y_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_q)
    load |=> (chrom_q == $past(chrom_in)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !load |=> $stable(chrom_q));

  // R5
  inv_second_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (chrom_nxt[OP_W-1:0] == 3'b101 && chrom_nxt[OP_W+SEL_W-1 -: SEL_W] == 3'b001)
      |-> (net_y == ~x_in[1]));

  // R6
  alias_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (chrom_nxt[FW-1:0] == 9'b110_000_110) |-> (net_y == 1'b0));

  // R7
  fwd_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (chrom_nxt[G1_OP+OP_W-1 -: OP_W] == 3'b011 &&
     chrom_nxt[G1_TOP -: SEL_W] >= 3'b011 && chrom_nxt[G1_TOP -: SEL_W] <= 3'b101 &&
     chrom_nxt[G1_TOP-SEL_W -: SEL_W] >= 3'b011 && chrom_nxt[G1_TOP-SEL_W -: SEL_W] <= 3'b101 &&
     chrom_nxt[FW-1:0] == 9'b011_000_110)
      |-> (net_y == ~x_in[0]));
endmodule

// File: tb/chromo_gate_net_test.sv
`timescale 1ns/1ps
module chromo_gate_net_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [35:0] chrom_in;
  logic [2:0]  x_in;
  logic        y;

  int n_run  = 0;
  int n_fail = 0;
  logic [35:0] model_chrom;
  bit   q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  chromo_gate_net uut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .chrom_in(chrom_in), .x_in(x_in), .y(y)
  );

  function automatic logic ref_eval(input logic [35:0] ch, input logic [2:0] x);
    logic s [0:6];
    logic [8:0] f;
    logic p, q, r;
    int ka, kb;
    for (int i = 0; i < 7; i++) s[i] = 1'b0;
    s[0] = x[0]; s[1] = x[1]; s[2] = x[2];
    for (int g = 0; g < 4; g++) begin
      f  = ch[35-9*g -: 9];
      ka = (f[8:6] >= 3'd6) ? int'(f[8:6]) - 6 : int'(f[8:6]);
      kb = (f[5:3] >= 3'd6) ? int'(f[5:3]) - 6 : int'(f[5:3]);
      p  = (ka < 3 + g) ? s[ka] : 1'b0;
      q  = (kb < 3 + g) ? s[kb] : 1'b0;
      case (f[2:0])
        3'd0: r = p & q;
        3'd1: r = !(p & q);
        3'd2: r = p | q;
        3'd3: r = !(p | q);
        3'd4: r = !p;
        3'd5: r = !q;
        3'd6: r = p ^ q;
        default: r = !(p ^ q);
      endcase
      s[3+g] = r;
    end
    return s[6];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: y=%b expected %b", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected output.
  task automatic step(input logic ld, input logic [35:0] ch, input logic [2:0] x, input string tag);
    @(negedge clk);
    load = ld; chrom_in = ch; x_in = x;
    if (ld) model_chrom = ch;
    q_exp.push_back(ref_eval(model_chrom, x));
    q_tag.push_back(tag);
  endtask

  // Monitor: compares after every edge that has a queued item.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) check(q_tag.pop_front(), y, q_exp.pop_front());
  end

  task automatic sweep(input logic [35:0] ch, input string tag);
    for (int x = 0; x < 8; x++) step(x == 0, ch, 3'(x), tag);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [35:0] sum_a, sum_b, carry, fwd;
    rst_n = 1'b0; load = 1'b0; chrom_in = '0; x_in = '0; model_chrom = '0;
    repeat (3) @(negedge clk);
    check("R1 reset output", y, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: all-zero chromosome gives y = a
    for (int x = 0; x < 8; x++) step(1'b0, 36'hFFF_FFF_FFF, 3'(x), "R1 zero chromosome");

    // R4 R9: sum network, gate III = a^b, gate IV = III^c
    sum_a = {9'b101_011_001, 9'b111_100_010, 9'b000_001_110, 9'b101_010_110};
    sum_b = {9'b010_101_111, 9'b011_000_100, 9'b000_001_110, 9'b101_010_110};
    sweep(sum_a, "R4 sum network");
    // R8: same useful part, other junk in gates I and II
    sweep(sum_b, "R8 off-path gates");
    // R4: carry network
    carry = {9'b000_001_000, 9'b000_001_110, 9'b100_010_000, 9'b011_101_010};
    sweep(carry, "R4 carry network");
    // R5: every gate type on gate IV, a and b
    for (int op = 0; op < 8; op++)
      sweep({27'h5A5_A5A5, 6'b000_001, 3'(op)}, "R5 gate type");
    // R6: alias codes 110/111 for a/b
    sweep({27'h0, 9'b110_111_110}, "R6 alias codes");
    sweep({27'h0, 9'b110_111_000}, "R6 alias codes and");
    // R7: forward and self references read 0
    fwd = {9'b011_100_011, 9'b100_101_010, 9'b000_000_000, 9'b011_000_110};
    sweep(fwd, "R7 forward reference");
    // R3 R2: load low ignores chrom_in, then a load applies at once
    for (int x = 0; x < 8; x++) step(1'b0, 36'h0_0000_0000, 3'(x), "R3 hold");
    step(1'b1, {27'h0, 9'b000_000_100}, 3'b001, "R2 load takes effect");
    step(1'b0, sum_a, 3'b000, "R3 hold after load");

    // R1: reset in mid-run
    repeat (3) @(negedge clk);
    load = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", y, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    model_chrom = '0;
    repeat (3) @(negedge clk);
    for (int x = 0; x < 8; x++) step(1'b0, carry, 3'(x), "R1 cleared chromosome");
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule